// File: doc/BRIEF.md
# Serial Channel Modem Status Register

This block holds the modem line status of one 16550-style serial channel. It watches four active-low modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents their true (complemented) levels in the upper nibble of an 8-bit read-only status byte. The lower nibble holds sticky change flags. Each external line passes through a parameterised synchronizer before any change detection happens. The block raises an interrupt request whenever a flag is set and the modem status interrupt is enabled.

A read of the byte is signalled by a level strobe from the host bus. The flags are cleared at the strobe's trailing edge. A change that arrives while the strobe is high is held back and applied at the trailing edge. If a flag was already set and its condition recurs during the read, the flag is cleared instead of being set again.

In loopback mode the four lines come from the channel's own modem control outputs instead of the pins. This lets software generate status changes, and interrupts, by writing those outputs. The block has no write path: host writes to this address have no effect.

Top module: `modem_stat_reg`

## Requirements
- R1: With loopback off, bits 7..4 of `stat_q` are carrier detect, ring, data-set-ready and clear-to-send (bit 7 down to bit 4). Each is the inverse of its pin, seen after SYNC_STAGES clock edges.
- R2: With `loop_en` high, bit 4 shows `ctl_bits[1]` (RTS), bit 5 shows `ctl_bits[0]` (DTR), bit 6 shows `ctl_bits[2]` (OUT1) and bit 7 shows `ctl_bits[3]` (OUT2). The four pins then change nothing in `stat_q`.
- R3: Bit 0, bit 1 and bit 3 set on any change of the effective clear-to-send, data-set-ready and carrier detect levels respectively. Once set, they hold until a read ends.
- R4: Bit 2 sets only when the effective ring bit (bit 6) falls from 1 to 0. A 0-to-1 change leaves it clear.
- R5: The falling edge of `rd_stb` clears bits 3..0 unless R6 applies. Bits 7..4 are never changed by a read.
- R6: A change seen while `rd_stb` is high leaves bits 3..0 unchanged during the read. The change sets its flag at the strobe's trailing edge, provided the flag was clear when the change occurred.
- R7: A change seen during a read whose flag is already set leaves that flag cleared after the trailing edge.
- R8: `irq` is high exactly when `ms_irq_en` is high and at least one of bits 3..0 is set.
- R9: While `rst_n` is low, bits 3..0 and `irq` are 0. A line that is steady through reset produces no flag after release.
- R10: In loopback, changing `ctl_bits` produces the flags of R3 and R4, and with `ms_irq_en` high it raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| pin_ri_n | input | 1 | Ring indicator line, active low, asynchronous |
| pin_dcd_n | input | 1 | Carrier detect line, active low, asynchronous |
| loop_en | input | 1 | Loopback mode from the modem control register |
| ctl_bits | input | 4 | Modem control outputs: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2 |
| ms_irq_en | input | 1 | Modem status interrupt enable |
| rd_stb | input | 1 | High while the host reads this register |
| stat_q | output | 8 | Status byte: levels in 7..4, change flags in 3..0 |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the pin-to-status latency a non-default value, so a design that hard-codes the synchronizer depth gets out of step with the bench model. At that depth, each pin change lands well clear of the read strobe edges, so the bench can place a change inside a read, before it, or after it. The loopback scenarios then drive the control bits directly, which puts the zero-latency path and pin isolation in reach on the same build.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned MSR_LINES = 4;
  // line order inside a vector: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier
  typedef logic [MSR_LINES-1:0] line_vec_t;

  // control bits: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2
  function automatic line_vec_t loop_view(input logic [3:0] ctl);
    line_vec_t v;
    v[0] = ctl[1];
    v[1] = ctl[0];
    v[2] = ctl[2];
    v[3] = ctl[3];
    return v;
  endfunction

  // change events: any toggle, except ring which reports only its falling status edge
  function automatic line_vec_t edge_events(input line_vec_t old_v, input line_vec_t new_v);
    line_vec_t e;
    e    = old_v ^ new_v;
    e[2] = old_v[2] & ~new_v[2];
    return e;
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] st [STAGES];

  // plain flops; the reset logic downstream waits for the chain to fill
  always_ff @(posedge clk) st[0] <= din;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) st[g] <= st[g-1];
  end

  assign dout = st[LAST];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
  import msr_pkg::*;
(
  input  line_vec_t  pins_n_sync,
  input  logic       loop_en,
  input  logic [3:0] ctl_bits,
  output line_vec_t  eff
);
  always_comb begin
    if (loop_en) eff = loop_view(ctl_bits);
    else         eff = ~pins_n_sync;
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t eff,
  input  logic      rd_stb,
  output line_vec_t delta_q,
  output line_vec_t pend_q,
  output line_vec_t ev,
  output logic      rd_fall
);
  line_vec_t prev_q;
  logic      rd_q;

  assign ev      = edge_events(prev_q, eff);
  assign rd_fall = rd_q & ~rd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= eff;
      delta_q <= '0;
      pend_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      prev_q <= eff;
      rd_q   <= rd_stb;
      if (rd_stb) begin
        pend_q <= pend_q | (ev & ~delta_q);
      end else if (rd_q) begin
        delta_q <= pend_q | ev;
        pend_q  <= '0;
      end else begin
        delta_q <= delta_q | ev;
      end
    end
  end
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts_n,
  input  logic       pin_dsr_n,
  input  logic       pin_ri_n,
  input  logic       pin_dcd_n,
  input  logic       loop_en,
  input  logic [3:0] ctl_bits,
  input  logic       ms_irq_en,
  input  logic       rd_stb,
  output logic [7:0] stat_q,
  output logic       irq
);
  line_vec_t pins_raw, pins_sync, eff;
  line_vec_t delta_q, pend_q, delta_ev;
  logic      rd_fall;

  assign pins_raw = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

  msr_sync #(.STAGES(SYNC_STAGES), .WIDTH(MSR_LINES)) u_sync (
    .clk (clk),
    .din (pins_raw),
    .dout(pins_sync)
  );

  msr_src_sel u_sel (
    .pins_n_sync(pins_sync),
    .loop_en    (loop_en),
    .ctl_bits   (ctl_bits),
    .eff        (eff)
  );

  msr_delta u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .eff    (eff),
    .rd_stb (rd_stb),
    .delta_q(delta_q),
    .pend_q (pend_q),
    .ev     (delta_ev),
    .rd_fall(rd_fall)
  );

  assign stat_q = {eff, delta_q};
  assign irq    = ms_irq_en & (|delta_q);
endmodule

// File: rtl/msr_chk.sv
module msr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic [3:0] ctl_bits,
  input logic       ms_irq_en,
  input logic       rd_stb,
  input logic [7:0] stat_q,
  input logic       irq,
  input logic [3:0] ev,
  input logic [3:0] pend,
  input logic       rd_fall
);
  assert_loop_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (stat_q[7:4] == {ctl_bits[3], ctl_bits[2], ctl_bits[0], ctl_bits[1]}));

  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  assert_ring_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev[2] |-> ($past(stat_q[6]) && !stat_q[6]));

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && ev == 4'b0 && pend == 4'b0) |=> (stat_q[3:0] == 4'b0));

  assert_read_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> $stable(stat_q[3:0]));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ms_irq_en && (stat_q[3:0] != 4'b0)));
endmodule

bind modem_stat_reg msr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .loop_en  (loop_en),
  .ctl_bits (ctl_bits),
  .ms_irq_en(ms_irq_en),
  .rd_stb   (rd_stb),
  .stat_q   (stat_q),
  .irq      (irq),
  .ev       (delta_ev),
  .pend     (pend_q),
  .rd_fall  (rd_fall)
);

// File: tb/modem_stat_reg_tb.sv
module modem_stat_reg_tb;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       loop_en = 1'b0;
  logic [3:0] ctl = 4'h0;
  logic       ien = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] stat_q;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R3";

  always #2.5 clk = ~clk;

  modem_stat_reg #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pin_cts_n(cts_n), .pin_dsr_n(dsr_n), .pin_ri_n(ri_n), .pin_dcd_n(dcd_n),
    .loop_en(loop_en), .ctl_bits(ctl), .ms_irq_en(ien), .rd_stb(rd),
    .stat_q(stat_q), .irq(irq)
  );

  // ---- reference model: pin history queue and behavioural flags ----
  logic [3:0] pinq[$];
  logic [3:0] m_prev = 4'h0, m_flag = 4'h0, m_hold = 4'h0;
  logic       m_rd_was = 1'b0;

  // level view in status-bit order: [0] cts, [1] dsr, [2] ri, [3] dcd
  function automatic logic [3:0] levels_now();
    logic [3:0] lv;
    if (loop_en) begin
      lv[0] = ctl[1]; lv[1] = ctl[0]; lv[2] = ctl[2]; lv[3] = ctl[3];
    end else begin
      lv = ~pinq[0];
    end
    return lv;
  endfunction

  initial for (int i = 0; i < SYNC; i++) pinq.push_back(4'hF);

  always @(posedge clk) begin
    logic [3:0] lv, chg;
    lv = levels_now();
    chg = 4'h0;
    for (int b = 0; b < 4; b++) begin
      if (b == 2) chg[b] = m_prev[b] && !lv[b];
      else        chg[b] = m_prev[b] != lv[b];
    end
    if (!rst_n) begin
      m_flag = 4'h0; m_hold = 4'h0; m_rd_was = 1'b0;
    end else begin
      if (rd) begin
        for (int b = 0; b < 4; b++) if (chg[b] && !m_flag[b]) m_hold[b] = 1'b1;
      end else if (m_rd_was) begin
        m_flag = m_hold | chg;
        m_hold = 4'h0;
      end else begin
        m_flag = m_flag | chg;
      end
      m_rd_was = rd;
    end
    m_prev = lv;
    pinq.push_back({dcd_n, ri_n, dsr_n, cts_n});
    void'(pinq.pop_front());
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(loop_en ? "R2" : "R1", {4'h0, stat_q[7:4]}, {4'h0, levels_now()});
      chk(cur_req, {4'h0, stat_q[3:0]}, {4'h0, m_flag});
      chk("R8", {7'h0, irq}, {7'h0, ien && (m_flag != 4'h0)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_read(input int n);
    rd = 1'b1; step(n);
    rd = 1'b0; step(3);
  endtask

  task automatic at_neg_chk(input string req, input logic [7:0] exp_s, input logic exp_i);
    @(negedge clk);
    chk(req, stat_q, exp_s);
    chk(req, {7'h0, irq}, {7'h0, exp_i});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(6);
    rst_n = 1'b1; ien = 1'b1;
    step(2);
    cur_req = "R9"; at_neg_chk("R9", 8'h00, 1'b0);
    // R1 R3: clear-to-send asserted
    cur_req = "R3"; cts_n = 1'b0; step(8);
    at_neg_chk("R3", 8'h11, 1'b1);
    // R5: read clears flags, level kept
    cur_req = "R5"; do_read(2);
    at_neg_chk("R5", 8'h10, 1'b0);
    // R4: ring asserts (no flag), then releases (flag)
    cur_req = "R4"; ri_n = 1'b0; step(8);
    at_neg_chk("R4", 8'h50, 1'b0);
    ri_n = 1'b1; step(8);
    at_neg_chk("R4", 8'h14, 1'b1);
    do_read(1);
    at_neg_chk("R5", 8'h10, 1'b0);
    // R6: change during read is deferred
    cur_req = "R6"; rd = 1'b1; dsr_n = 1'b0; step(8);
    at_neg_chk("R6", 8'h30, 1'b0);
    rd = 1'b0; step(3);
    at_neg_chk("R6", 8'h32, 1'b1);
    do_read(2);
    at_neg_chk("R5", 8'h30, 1'b0);
    // R7: set flag, recur during read, ends cleared
    cur_req = "R7"; dcd_n = 1'b0; step(8);
    at_neg_chk("R7", 8'hB8, 1'b1);
    rd = 1'b1; dcd_n = 1'b1; step(8);
    rd = 1'b0; step(3);
    at_neg_chk("R7", 8'h30, 1'b0);
    // R2 R10: loopback
    cur_req = "R10"; loop_en = 1'b1; ctl = 4'h0; step(3);
    at_neg_chk("R10", 8'h03, 1'b1);
    do_read(1);
    at_neg_chk("R5", 8'h00, 1'b0);
    cur_req = "R2"; cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b0; dcd_n = 1'b0; step(8);
    at_neg_chk("R2", 8'h00, 1'b0);
    cur_req = "R10"; ctl = 4'b0010; step(2);
    at_neg_chk("R10", 8'h11, 1'b1);
    ien = 1'b0; step(1);
    at_neg_chk("R8", 8'h11, 1'b0);
    ien = 1'b1; do_read(1);
    ctl = 4'b0110; step(2);
    at_neg_chk("R10", 8'h50, 1'b0);
    ctl = 4'b0010; step(2);
    at_neg_chk("R10", 8'h14, 1'b1);
    do_read(1);
    // R9: reset with a line held active, no spurious flag
    cur_req = "R9"; loop_en = 1'b0; ctl = 4'h0;
    cts_n = 1'b0; ri_n = 1'b1; dcd_n = 1'b1;
    rst_n = 1'b0; step(6);
    @(negedge clk); chk("R9", {4'h0, stat_q[3:0], 3'b0, irq}, 8'h00);
    step(1); rst_n = 1'b1; step(4);
    at_neg_chk("R9", 8'h10, 1'b0);
    step(2);
    finish_run();
  end
endmodule